// File: doc/BRIEF.md
# Split-Screen Display Line Address Generator

This block produces display-buffer word addresses for a raster refresh engine that can show two screen regions, one above the other. A byte-wide host register port programs two 20-bit word start addresses, one per region, an 11-bit line stride and an 11-bit split line index. A timing port supplies three strobes: frame start, line start and pixel-word fetch. The block outputs the word address of the current fetch and the start word of the current line.

Host writes go to shadow registers. The generator copies them into its working set only on frame start, so a frame is never built from a mix of old and new settings. Each line starts one stride past the start of the line before it. The stride may be wider than the visible line, which lets the raster show a window into a larger virtual image. When the line counter reaches the split index, the line start reloads from the second region's start address. Sub-word pixel panning is handled elsewhere, so these outputs are whole-word addresses.

Top module: `split_line_addr_gen`

## Requirements
- R1: After reset, every register reads back as zero, `line_addr_o` and `fetch_addr_o` are zero, and `screen_sel_o` is 0.
- R2: The register map is as follows.
  - Offset 0 holds first-region start bits 7:0, offset 1 holds bits 15:8, and offset 2 holds bits 19:16 in bits 3:0.
  - Offsets 3, 4 and 5 hold the second-region start in the same layout.
  - Offset 6 holds stride bits 7:0, and offset 7 holds stride bits 10:8 in bits 2:0.
  - Offset 8 holds split index bits 7:0, and offset 9 holds split bits 10:8 in bits 2:0.
  - Unused bits read as zero, and offsets 10 to 15 read as zero.
- R3: Register writes do not change `line_addr_o` or `fetch_addr_o` until the next frame start. A write in the same cycle as a frame start is not part of that frame.
- R4: On frame start, the line counter clears. Both outputs load the first-region start and `screen_sel_o` becomes 0. If the split index is 0, both outputs load the second-region start and `screen_sel_o` becomes 1 instead.
- R5: On line start, the line address advances by the stride, and `fetch_addr_o` loads the new line address one cycle after the strobe.
- R6: On a fetch strobe, `fetch_addr_o` increments by one. Priority is frame start, then line start, then fetch; a lower-priority strobe in the same cycle is dropped.
- R7: When a line start brings the line counter equal to the split index, the line address loads the second-region start and `screen_sel_o` becomes 1. Later lines add the stride to that address.
- R8: A stride of any value up to 2047 is used unclamped. A split index the frame never reaches leaves `screen_sel_o` at 0 for the whole frame.
- R9: All address arithmetic wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from `reg_addr_i` |
| frame_start_i | input | 1 | Frame start strobe |
| line_start_i | input | 1 | Line start strobe |
| fetch_i | input | 1 | Pixel-word fetch strobe |
| line_addr_o | output | 20 | Start word of the current line |
| fetch_addr_o | output | 20 | Word address of the current fetch |
| screen_sel_o | output | 1 | 0 for the first region, 1 once the split has been passed |

## Verification
Several pairs of actions can fall in the same cycle.

- A host write can land in the cycle in which frame start copies the shadow registers. The bench drives the write and the frame strobe on the same edge. It then checks that the frame uses the old value and that the following frame uses the new one.
- A fetch strobe can coincide with a line start. The bench asserts both together and checks that the fetch address equals the new line start, not that value plus one.
- A frame start can coincide with a line start. The bench asserts both together and checks that the outputs hold the first-region start.

// File: rtl/slag_pkg.sv
package slag_pkg;
  localparam int ADDR_W   = 20;
  localparam int STRIDE_W = 11;
  localparam int LINE_W   = 11;
  localparam int REG_AW   = 4;
  localparam int DATA_W   = 8;

  localparam logic [REG_AW-1:0] OFS_A0 = 4'd0;
  localparam logic [REG_AW-1:0] OFS_A1 = 4'd1;
  localparam logic [REG_AW-1:0] OFS_A2 = 4'd2;
  localparam logic [REG_AW-1:0] OFS_B0 = 4'd3;
  localparam logic [REG_AW-1:0] OFS_B1 = 4'd4;
  localparam logic [REG_AW-1:0] OFS_B2 = 4'd5;
  localparam logic [REG_AW-1:0] OFS_S0 = 4'd6;
  localparam logic [REG_AW-1:0] OFS_S1 = 4'd7;
  localparam logic [REG_AW-1:0] OFS_P0 = 4'd8;
  localparam logic [REG_AW-1:0] OFS_P1 = 4'd9;

  typedef struct packed {
    logic [ADDR_W-1:0]   base_a;
    logic [ADDR_W-1:0]   base_b;
    logic [STRIDE_W-1:0] stride;
    logic [LINE_W-1:0]   split;
  } slag_cfg_t;
endpackage

// File: rtl/slag_regfile.sv
module slag_regfile
  import slag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output slag_cfg_t         cfg_o
);
  localparam int HI_A = ADDR_W - 16;
  localparam int HI_S = STRIDE_W - 8;
  localparam int HI_P = LINE_W - 8;

  slag_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_A0: cfg_q.base_a[7:0]        <= wdata_i;
        OFS_A1: cfg_q.base_a[15:8]       <= wdata_i;
        OFS_A2: cfg_q.base_a[ADDR_W-1:16] <= wdata_i[HI_A-1:0];
        OFS_B0: cfg_q.base_b[7:0]        <= wdata_i;
        OFS_B1: cfg_q.base_b[15:8]       <= wdata_i;
        OFS_B2: cfg_q.base_b[ADDR_W-1:16] <= wdata_i[HI_A-1:0];
        OFS_S0: cfg_q.stride[7:0]        <= wdata_i;
        OFS_S1: cfg_q.stride[STRIDE_W-1:8] <= wdata_i[HI_S-1:0];
        OFS_P0: cfg_q.split[7:0]         <= wdata_i;
        OFS_P1: cfg_q.split[LINE_W-1:8]  <= wdata_i[HI_P-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_A0: rdata_o = cfg_q.base_a[7:0];
      OFS_A1: rdata_o = cfg_q.base_a[15:8];
      OFS_A2: rdata_o = {{(DATA_W-HI_A){1'b0}}, cfg_q.base_a[ADDR_W-1:16]};
      OFS_B0: rdata_o = cfg_q.base_b[7:0];
      OFS_B1: rdata_o = cfg_q.base_b[15:8];
      OFS_B2: rdata_o = {{(DATA_W-HI_A){1'b0}}, cfg_q.base_b[ADDR_W-1:16]};
      OFS_S0: rdata_o = cfg_q.stride[7:0];
      OFS_S1: rdata_o = {{(DATA_W-HI_S){1'b0}}, cfg_q.stride[STRIDE_W-1:8]};
      OFS_P0: rdata_o = cfg_q.split[7:0];
      OFS_P1: rdata_o = {{(DATA_W-HI_P){1'b0}}, cfg_q.split[LINE_W-1:8]};
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_A0) |=> cfg_o.base_a[7:0] == $past(wdata_i));
  // R2
  hi_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_S1 || addr_i == OFS_P1) |-> rdata_o[DATA_W-1:HI_S] == '0);
endmodule

// File: rtl/slag_frame_latch.sv
module slag_frame_latch
  import slag_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      frame_start_i,
  input  slag_cfg_t cfg_i,
  output slag_cfg_t act_o
);
  slag_cfg_t act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_q <= '0;
    else if (frame_start_i) act_q <= cfg_i;
  end

  assign act_o = act_q;

  // R3
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> act_o == $past(act_o));
endmodule

// File: rtl/slag_addr_walk.sv
module slag_addr_walk
  import slag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              fetch_i,
  input  slag_cfg_t         cfg_i,
  input  slag_cfg_t         act_i,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              sel_o
);
  localparam int PAD_W = ADDR_W - STRIDE_W;
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] cnt_q, cnt_nxt;
  logic [ADDR_W-1:0] line_q, fetch_q, frame_base, line_nxt, step_sum;
  logic              sel_q, split_hit, frame_sel;

  always_comb begin
    frame_sel  = (cfg_i.split == '0);
    frame_base = frame_sel ? cfg_i.base_b : cfg_i.base_a;
    cnt_nxt    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    split_hit  = !sel_q && (cnt_nxt == act_i.split);
    step_sum   = line_q + {{PAD_W{1'b0}}, act_i.stride};
    line_nxt   = split_hit ? act_i.base_b : step_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      line_q  <= '0;
      fetch_q <= '0;
      sel_q   <= 1'b0;
    end else if (frame_start_i) begin
      cnt_q   <= '0;
      line_q  <= frame_base;
      fetch_q <= frame_base;
      sel_q   <= frame_sel;
    end else if (line_start_i) begin
      cnt_q   <= cnt_nxt;
      line_q  <= line_nxt;
      fetch_q <= line_nxt;
      sel_q   <= sel_q | split_hit;
    end else if (fetch_i) begin
      fetch_q <= fetch_q + 1'b1;
    end
  end

  assign line_addr_o  = line_q;
  assign fetch_addr_o = fetch_q;
  assign sel_o        = sel_q;

  // R6
  fetch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && !line_start_i && !frame_start_i)
      |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);
  // R5
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i || frame_start_i) |=> fetch_addr_o == line_addr_o);
  // R3
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && !frame_start_i) |=> ($stable(line_addr_o) && $stable(sel_o)));
  // R7
  sel_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_o) |-> $past(frame_start_i));
  // R5
  stride_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !frame_start_i && sel_o)
      |=> line_addr_o == $past(line_addr_o) + {{PAD_W{1'b0}}, $past(act_i.stride)});
endmodule

// File: rtl/split_line_addr_gen.sv
module split_line_addr_gen
  import slag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              fetch_i,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              screen_sel_o
);
  slag_cfg_t shadow_cfg, active_cfg;

  slag_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (shadow_cfg)
  );

  slag_frame_latch u_latch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .cfg_i         (shadow_cfg),
    .act_o         (active_cfg)
  );

  slag_addr_walk u_walk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_start_i  (line_start_i),
    .fetch_i       (fetch_i),
    .cfg_i         (shadow_cfg),
    .act_i         (active_cfg),
    .line_addr_o   (line_addr_o),
    .fetch_addr_o  (fetch_addr_o),
    .sel_o         (screen_sel_o)
  );
endmodule

// File: tb/split_line_addr_gen_tb.sv
`timescale 1ns/1ps
module split_line_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        fs = 1'b0, ls = 1'b0, fe = 1'b0;
  logic [19:0] line_addr, fetch_addr;
  logic        sel;
  int checks = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_line_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .frame_start_i(fs),
    .line_start_i(ls), .fetch_i(fe), .line_addr_o(line_addr),
    .fetch_addr_o(fetch_addr), .screen_sel_o(sel)
  );

  typedef struct packed {
    logic [19:0] a;
    logic [19:0] b;
    logic [10:0] stride;
    logic [10:0] split;
    logic [19:0] exp_l3;
    logic        exp_sel;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{20'h00100, 20'h50000, 11'd40,    11'd100,   20'h00178, 1'b0}, // R5 R8
    '{20'h12345, 20'hABCDE, 11'h7FF,   11'd2,     20'hAC4DD, 1'b1}, // R7 R8
    '{20'hFFF00, 20'h00000, 11'h100,   11'h7FF,   20'h00200, 1'b0}, // R9 R8
    '{20'h00010, 20'h20000, 11'd5,     11'd0,     20'h2000F, 1'b1}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic strobe(input logic f, input logic l, input logic x);
    @(negedge clk); fs = f; ls = l; fe = x;
    @(negedge clk); fs = 1'b0; ls = 1'b0; fe = 1'b0;
  endtask

  task automatic prog(input logic [19:0] a, input logic [19:0] b,
                      input logic [10:0] s, input logic [10:0] p);
    wr(4'd0, a[7:0]);  wr(4'd1, a[15:8]); wr(4'd2, {4'h0, a[19:16]});
    wr(4'd3, b[7:0]);  wr(4'd4, b[15:8]); wr(4'd5, {4'h0, b[19:16]});
    wr(4'd6, s[7:0]);  wr(4'd7, {5'h0, s[10:8]});
    wr(4'd8, p[7:0]);  wr(4'd9, {5'h0, p[10:8]});
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 line", {12'h0, line_addr}, 32'h0);
    chk("R1 fetch", {12'h0, fetch_addr}, 32'h0);
    chk("R1 sel", {31'h0, sel}, 32'h0);
    for (int i = 0; i < 16; i++) rd_chk("R1 regs", 4'(i), 8'h00);

    // vector table
    for (int v = 0; v < 4; v++) begin
      prog(VEC[v].a, VEC[v].b, VEC[v].stride, VEC[v].split);
      strobe(1'b1, 1'b0, 1'b0);
      chk("R4 frame line", {12'h0, line_addr},
          {12'h0, (VEC[v].split == 0) ? VEC[v].b : VEC[v].a});
      for (int k = 0; k < 3; k++) strobe(1'b0, 1'b1, 1'b0);
      chk("R5/R7 line3", {12'h0, line_addr}, {12'h0, VEC[v].exp_l3});
      chk("R7 sel", {31'h0, sel}, {31'h0, VEC[v].exp_sel});
      for (int k = 0; k < 3; k++) strobe(1'b0, 1'b0, 1'b1);
      chk("R6 fetch", {12'h0, fetch_addr}, {12'h0, VEC[v].exp_l3 + 20'd3});
    end

    // R2 reserved bits and unmapped offsets
    wr(4'd2, 8'hFF); rd_chk("R2 a_hi", 4'd2, 8'h0F);
    wr(4'd5, 8'hFF); rd_chk("R2 b_hi", 4'd5, 8'h0F);
    wr(4'd7, 8'hFF); rd_chk("R2 s_hi", 4'd7, 8'h07);
    wr(4'd9, 8'hFF); rd_chk("R2 p_hi", 4'd9, 8'h07);
    wr(4'd12, 8'hFF); rd_chk("R2 unmapped", 4'd12, 8'h00);
    wr(4'd1, 8'hA5); rd_chk("R2 a_mid", 4'd1, 8'hA5);

    // R3 writes deferred to frame start
    prog(20'h00200, 20'h40000, 11'd16, 11'h7FF);
    strobe(1'b1, 1'b0, 1'b0);
    wr(4'd0, 8'h55);
    wr(4'd6, 8'h20);
    chk("R3 no early effect", {12'h0, line_addr}, 32'h00200);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R3 old stride", {12'h0, line_addr}, 32'h00210);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R3 new base", {12'h0, line_addr}, 32'h00255);

    // R3 write coincident with frame start
    @(negedge clk); fs = 1'b1; we = 1'b1; addr = 4'd0; wdata = 8'h77;
    @(negedge clk); fs = 1'b0; we = 1'b0;
    chk("R3 same cycle old", {12'h0, line_addr}, 32'h00255);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R3 same cycle next", {12'h0, line_addr}, 32'h00277);

    // R6 priorities
    strobe(1'b0, 1'b0, 1'b1);
    chk("R6 single fetch", {12'h0, fetch_addr}, 32'h00278);
    strobe(1'b0, 1'b1, 1'b1);
    chk("R6 line over fetch line", {12'h0, line_addr}, 32'h00297);
    chk("R6 line over fetch fetch", {12'h0, fetch_addr}, 32'h00297);
    strobe(1'b1, 1'b1, 1'b1);
    chk("R6 frame over line", {12'h0, line_addr}, 32'h00277);
    chk("R6 frame over fetch", {12'h0, fetch_addr}, 32'h00277);

    // R9 fetch wrap
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF); wr(4'd2, 8'h0F);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R9 base", {12'h0, fetch_addr}, 32'hFFFFF);
    strobe(1'b0, 1'b0, 1'b1);
    chk("R9 wrap", {12'h0, fetch_addr}, 32'h00000);

    // R8 split far beyond lines run
    for (int k = 0; k < 20; k++) strobe(1'b0, 1'b1, 1'b0);
    chk("R8 no split", {31'h0, sel}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule